// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte comes in through a valid/ready handshake. The frame layout is read at run time from an 8-bit line control byte. A frame is one start bit (low), then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then 1, 1.5 or 2 stop bits (high). Timing comes from a one-cycle `baud_tick` strobe made by an external divider. Each bit period lasts 16 ticks, so a half stop bit lasts 8 ticks.

The control byte is decoded as follows:

- Bits [1:0] select the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- Bit 2 selects long stop.
- Bit 3 enables parity.
- Bit 4 selects the parity sense.
- Bit 5 selects stick parity.
- Bit 6 forces a break.
- Bit 7 is ignored.

The layout is latched when a byte is accepted, so the control byte may change during a frame without harm. The break bit is the exception and acts at once.

Back-pressure rules: `in_ready` is high only while the transmitter is idle and no break is asserted. A byte transfers on a clock edge where `in_valid` and `in_ready` are both high. A producer that keeps `in_valid` high while `in_ready` is low loses nothing: its byte waits until the current frame has ended.

Top module: `serial_tx_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1 (mark) and `in_ready` is 1 unless break is asserted.
- R2: On the cycle after a handshake, `txd` drops to 0 for one bit period of 16 baud ticks (the start bit).
- R3: The data bits follow the start bit, least significant bit first. Each lasts 16 ticks. The count is 5, 6, 7 or 8 for control bits [1:0] = 00, 01, 10, 11; higher data bits are not sent.
- R4: With control bit 3 = 0, no parity bit is sent, whatever bits 4 and 5 hold.
- R5: With bit 3 = 1 and bit 5 = 0, a parity bit of 16 ticks follows the data. Bit 4 = 0 makes the count of ones in the sent data bits plus the parity bit odd; bit 4 = 1 makes it even.
- R6: With bit 3 = 1 and bit 5 = 1, the parity bit is a constant: 1 when bit 4 = 0, and 0 when bit 4 = 1.
- R7: The stop level (1) lasts 16 ticks when bit 2 = 0. When bit 2 = 1 it lasts 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words.
- R8: While control bit 6 = 1, `txd` is 0 and `in_ready` is 0 in the same cycle, and any frame in progress is abandoned.
- R9: After break is cleared, `txd` stays at mark for 16 ticks before `in_ready` rises again. A new break during this period restarts the count.
- R10: The frame layout is captured at the handshake; changes to control bits 0 to 5 during a frame do not alter that frame.
- R11: `in_ready` falls on the cycle after a handshake and rises again on the cycle after the last stop tick. A byte held valid meanwhile is accepted then.
- R12: Bit periods advance only on `baud_tick`; without ticks the line level holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle strobe, 16 per bit period |
| line_ctrl | input | 8 | Frame layout and break control byte |
| in_valid | input | 1 | Producer offers a byte |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial output, idle high |

## Verification
The timing of each result is fixed:

- Break acts on `txd` and `in_ready` in the same cycle it is applied.
- A handshake changes `txd` (start bit) and `in_ready` on the very next clock edge.
- Every later line transition happens on the edge that consumes the 16th tick of a bit period, or the 24th or 32nd tick of a long stop.

A behavioural model in the bench turns each accepted byte into a queue of (level, tick count) segments and advances it on the same edges. Both `txd` and `in_ready` are compared against it on every falling clock edge, half a cycle after those updates, so each check samples a settled value.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_GUARD
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wsel;      // word length code, 5 + wsel bits
    logic       long_stop; // 1.5 or 2 stop bits
    logic       par_en;
    logic       par_eps;   // even sense / stick value select
    logic       par_stick;
  } frame_fmt_t;

  function automatic frame_fmt_t unpack_ctrl(input logic [5:0] c);
    frame_fmt_t f;
    f.wsel      = c[1:0];
    f.long_stop = c[2];
    f.par_en    = c[3];
    f.par_eps   = c[4];
    f.par_stick = c[5];
    return f;
  endfunction

endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] len,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  assign done = tick && !clr && (cnt == len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || done) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R12: the period counter moves only on a tick
  p_count_needs_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));

  // R7: the count never passes the active segment length
  p_count_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len);

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity #(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        wsel,
  input  logic              eps,
  input  logic              stick,
  output logic              par_bit
);

  logic [DATA_W-1:0] keep;
  logic              ones_odd;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign keep[g] = (g < MIN_W) || (32'(g) < 32'(MIN_W) + 32'(wsel));
  end

  assign ones_odd = ^(data & keep);

  always_comb begin
    if (stick)    par_bit = ~eps;
    else if (eps) par_bit = ones_odd;
    else          par_bit = ~ones_odd;
  end

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
  import sertx_pkg::*;
#(
  parameter int OS     = 16,
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk,
  input  logic              tick,
  input  logic              accept,
  input  logic [DATA_W-1:0] din,
  input  frame_fmt_t        fmt_in,
  input  logic              seg_done,
  input  logic              par_bit,
  output tx_state_e         state,
  output logic [CNT_W-1:0]  seg_len,
  output logic              seg_clr,
  output logic [DATA_W-1:0] cap_data,
  output frame_fmt_t        cap_fmt,
  output logic              line_lvl
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;
  logic [CNT_W-1:0] stop_len;

  assign last_idx = IDX_W'(MIN_W - 1) + IDX_W'(cap_fmt.wsel);
  assign seg_clr  = brk | accept;

  always_comb begin
    if (!cap_fmt.long_stop)     stop_len = CNT_W'(OS);
    else if (cap_fmt.wsel == 0) stop_len = CNT_W'(OS + OS / 2);
    else                        stop_len = CNT_W'(2 * OS);
  end

  always_comb begin
    case (state)
      ST_STOP: seg_len = stop_len;
      default: seg_len = CNT_W'(OS);
    endcase
  end

  always_comb begin
    case (state)
      ST_START: line_lvl = 1'b0;
      ST_DATA:  line_lvl = cap_data[idx];
      ST_PAR:   line_lvl = par_bit;
      default:  line_lvl = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      cap_data <= '0;
      cap_fmt  <= '0;
    end else if (brk) begin
      state <= ST_GUARD;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_START;
            cap_data <= din;
            cap_fmt  <= fmt_in;
            idx      <= '0;
          end
        end
        ST_START: if (seg_done) state <= ST_DATA;
        ST_DATA: begin
          if (seg_done) begin
            if (idx == last_idx) begin
              state <= cap_fmt.par_en ? ST_PAR : ST_STOP;
              idx   <= '0;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        ST_PAR:   if (seg_done) state <= ST_STOP;
        ST_STOP:  if (seg_done) state <= ST_IDLE;
        ST_GUARD: if (seg_done) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R2: a handshake starts the frame with the start bit
  p_start_follows_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> state == ST_START);

  // R8: break abandons whatever was in progress
  p_break_abandons_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> state == ST_GUARD);

  // R9: the recovery period only ever leads back to idle
  p_guard_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_GUARD |=> (state == ST_GUARD || state == ST_IDLE));

  // R12: no tick, no progress through the frame
  p_hold_without_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !brk && state != ST_IDLE) |=> state == $past(state));

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
  import sertx_pkg::*;
#(
  parameter int OS     = 16,
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [7:0]        line_ctrl,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd
);

  localparam int CNT_W = $clog2(2 * OS + 1);

  tx_state_e         state;
  frame_fmt_t        fmt_in;
  frame_fmt_t        cap_fmt;
  logic [DATA_W-1:0] cap_data;
  logic [CNT_W-1:0]  seg_len;
  logic              seg_clr;
  logic              seg_done;
  logic              par_bit;
  logic              line_lvl;
  logic              brk;
  logic              accept;
  logic              unused_ctrl;

  assign brk         = line_ctrl[6];
  assign unused_ctrl = line_ctrl[7];
  assign fmt_in      = unpack_ctrl(line_ctrl[5:0]);
  assign in_ready    = (state == ST_IDLE) && !brk;
  assign accept      = in_valid && in_ready;
  assign txd         = brk ? 1'b0 : line_lvl;

  sertx_seq #(
    .OS(OS), .DATA_W(DATA_W), .MIN_W(MIN_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .brk(brk), .tick(baud_tick), .accept(accept),
    .din(in_data), .fmt_in(fmt_in), .seg_done(seg_done), .par_bit(par_bit),
    .state(state), .seg_len(seg_len), .seg_clr(seg_clr),
    .cap_data(cap_data), .cap_fmt(cap_fmt), .line_lvl(line_lvl)
  );

  sertx_bitclk #(.CNT_W(CNT_W)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .clr(seg_clr),
    .len(seg_len), .done(seg_done)
  );

  sertx_parity #(.DATA_W(DATA_W), .MIN_W(MIN_W)) u_parity (
    .data(cap_data), .wsel(cap_fmt.wsel), .eps(cap_fmt.par_eps),
    .stick(cap_fmt.par_stick), .par_bit(par_bit)
  );

  // R11: a handshake takes the transmitter out of idle
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R7: the line is at mark throughout the stop period
  p_stop_is_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && !brk) |-> txd);

  // R1: mark on the line whenever idle without break
  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !brk) |-> (txd && in_ready));

endmodule

// File: tb/tb_serial_tx_framer.sv
module tb_serial_tx_framer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [7:0] line_ctrl = 8'h03;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       txd;

  always #2 clk = ~clk;

  serial_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .line_ctrl(line_ctrl),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // tick generator
  int tick_div = 4;
  bit tick_en  = 1'b1;
  int ph       = 0;
  always @(negedge clk) begin
    ph = (ph + 1) % tick_div;
    baud_tick <= tick_en && (ph == 0);
  end

  // reference model: queue of line segments
  int    lv_q[$];
  int    ln_q[$];
  string tg_q[$];
  int    m_mode = 0;   // 0 idle, 1 frame, 2 recovery after break
  int    cur_lvl = 1;
  int    cur_left = 0;
  string cur_tag = "R1";
  int    guard_left = 0;

  task automatic push_seg(input int lv, input int ln, input string tg);
    lv_q.push_back(lv); ln_q.push_back(ln); tg_q.push_back(tg);
  endtask

  task automatic pop_seg();
    cur_lvl = lv_q.pop_front(); cur_left = ln_q.pop_front(); cur_tag = tg_q.pop_front();
  endtask

  task automatic build_frame(input logic [7:0] c, input logic [7:0] d);
    int wl;
    int ones;
    int p;
    wl = 5 + int'(c[1:0]);
    ones = 0;
    push_seg(0, 16, "R2");
    for (int i = 0; i < wl; i++) begin
      push_seg(int'(d[i]), 16, "R3");
      ones += int'(d[i]);
    end
    if (c[3]) begin
      if (c[5]) begin
        p = c[4] ? 0 : 1;
        push_seg(p, 16, "R6");
      end else begin
        p = c[4] ? (ones % 2) : 1 - (ones % 2);
        push_seg(p, 16, "R5");
      end
    end
    push_seg(1, !c[2] ? 16 : (wl == 5 ? 24 : 32), c[3] ? "R7" : "R4 R7");
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; lv_q.delete(); ln_q.delete(); tg_q.delete();
    end else if (line_ctrl[6]) begin
      m_mode = 2; guard_left = 16; lv_q.delete(); ln_q.delete(); tg_q.delete();
    end else begin
      case (m_mode)
        0: if (in_valid) begin
             build_frame(line_ctrl, in_data);
             pop_seg();
             m_mode = 1;
           end
        1: if (baud_tick) begin
             cur_left--;
             if (cur_left == 0) begin
               if (lv_q.size() == 0) m_mode = 0;
               else pop_seg();
             end
           end
        default: if (baud_tick) begin
             guard_left--;
             if (guard_left == 0) m_mode = 0;
           end
      endcase
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    int    exp_txd;
    int    exp_rdy;
    string tag;
    cycles++;
    if (cycles > 2) begin
      exp_rdy = (m_mode == 0 && !line_ctrl[6]) ? 1 : 0;
      if (line_ctrl[6])     begin exp_txd = 0;       tag = "R8"; end
      else if (m_mode == 1) begin exp_txd = cur_lvl; tag = cur_tag; end
      else if (m_mode == 2) begin exp_txd = 1;       tag = "R9"; end
      else                  begin exp_txd = 1;       tag = "R1"; end
      checks++;
      if (int'(txd) != exp_txd) begin
        fails++;
        $display("FAIL %s txd at cycle %0d: got %0d expected %0d", tag, cycles, txd, exp_txd);
      end
      checks++;
      if (int'(in_ready) != exp_rdy) begin
        fails++;
        $display("FAIL R11 in_ready at cycle %0d: got %0d expected %0d", cycles, in_ready, exp_rdy);
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R11 watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (m_mode != 0) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    line_ctrl = c; in_valid = 1'b1; in_data = d;
    @(negedge clk);
    while (m_mode == 0) @(negedge clk);
    in_valid = 1'b0; in_data = 8'h00;
    wait_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;                       // R1: reset state compared from here
    repeat (10) @(negedge clk);
    send(8'h03, 8'hA5);                 // R3: 8 data bits, one stop
    send(8'h08, 8'h16);                 // R5: 5 bits odd parity
    send(8'h0C, 8'h13);                 // R7: 5 bits with 1.5 stop bits
    send(8'h1D, 8'h2B);                 // R5: 6 bits even parity, 2 stop
    send(8'h2A, 8'h55);                 // R6: 7 bits stick parity, forced 1
    send(8'h3F, 8'hC3);                 // R6: 8 bits stick parity, forced 0
    send(8'h36, 8'hFF);                 // R4: parity off, bits 4/5 set
    send(8'h18, 8'h00);                 // R5: zero data, even sense

    // R10: layout changes during a frame are ignored
    @(negedge clk);
    line_ctrl = 8'h0B; in_valid = 1'b1; in_data = 8'h9C;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (200) @(negedge clk);
    line_ctrl = 8'h34;
    wait_idle();

    // R8, R9: break mid-frame, release, break again during recovery
    @(negedge clk);
    line_ctrl = 8'h03; in_valid = 1'b1; in_data = 8'h5A;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (150) @(negedge clk);
    line_ctrl = 8'h43;
    repeat (40) @(negedge clk);
    line_ctrl = 8'h03;
    repeat (30) @(negedge clk);
    line_ctrl = 8'h43;
    repeat (5) @(negedge clk);
    line_ctrl = 8'h03;
    wait_idle();
    send(8'h03, 8'h81);

    // R11: valid held through a frame, next byte taken after last stop tick
    @(negedge clk);
    line_ctrl = 8'h01; in_valid = 1'b1; in_data = 8'h2D;
    @(negedge clk);
    in_data = 8'h1E;
    while (m_mode != 0) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle();

    // R12: ticks stop mid-frame and the line holds
    @(negedge clk);
    line_ctrl = 8'h0F; in_valid = 1'b1; in_data = 8'h6E;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (120) @(negedge clk);
    tick_en = 1'b0;
    repeat (100) @(negedge clk);
    tick_en = 1'b1;
    tick_div = 3;
    wait_idle();

    // R8: break while idle
    line_ctrl = 8'hC3;
    repeat (20) @(negedge clk);
    line_ctrl = 8'h83;                  // bit 7 has no effect
    wait_idle();
    send(8'h83, 8'h7E);

    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule